// File: doc/BRIEF.md
# Three-Bank Level Interrupt Controller

This block gathers 96 level-sensitive interrupt request lines, organised as three banks of 32, and reduces them to two processor-facing outputs: a normal interrupt and a fast interrupt. Each line holds a pending bit, a mask bit, a software-raised bit, a 6-bit priority and a steer bit. The steer bit routes the line to the fast output instead of the normal one. For each output, an arbiter picks the unmasked pending line with the smallest priority value. When priorities tie, the line with the highest number wins.

Software uses a word-addressed 4 KB register window. Global registers sit in the first 0x80 bytes. Bank registers sit in the 0x80..0xFF window, where each bank has its own 0x20 slot. Per-line level words start at 0x100. Each output behaves as a one-shot agreement. Once it rises, it stays high and its winner code stays frozen until software re-arms that output through the control register. The output then drops, and arbitration runs again on the next cycle. A global mask bit stops either output from rising, and a soft-reset bit returns all state to its reset values.

Top module: `multi_bank_intc`

## Requirements
- R1: After reset, both outputs are low, every bank mask reads 0xFFFFFFFF, revision (0x000) reads 0x21, status (0x014) reads 1, and both winner codes (IRQ at 0x040, FIQ at 0x044) read 0.
- R2: On a rising input, the line's raw bit (bank slot +0x00) and its pending bit are set on the next clock. The IRQ view (+0x18) reads pending AND NOT mask AND NOT steer. The FIQ view (+0x1C) reads pending AND NOT mask AND steer. Bank b's slot starts at 0x80 + 0x20*b.
- R3: When any input of a bank falls, that whole bank's pending word becomes its new raw inputs OR its software bits.
- R4: The mask register (+0x04) is written whole. A write to +0x08 clears the mask bits that are set in the data. A write to +0x0C sets the mask bits that are set in the data. Both +0x08 and +0x0C read 0.
- R5: A write to software-set (+0x10) ORs the data into the software bits and into pending, and reading +0x10 returns the software bits. A write to software-clear (+0x14) clears software bits, and pending becomes the software bits AND raw inputs.
- R6: While an output is armed and the global mask is clear, the output rises one clock after some routed line is unmasked and pending. The winner code is latched at that moment: the lowest priority value wins, and on a tie the highest line number (bank*32+line) wins.
- R7: A line whose steer bit is 1 drives only the FIQ output and FIQ code. A line whose steer bit is 0 drives only the IRQ output and IRQ code.
- R8: A raised output stays high with a frozen code until a control (0x048) write with bit 0 set (IRQ) or bit 1 set (FIQ). That write drops the output on the same clock, and the output can rise again one clock later.
- R9: Control bit 2 is a global mask. While it is set, neither output rises. It reads back in bit 2.
- R10: The level word for bank b, line l is at 0x100 + 0x80*b + 4*l. Bits 7:2 hold the priority and bit 0 holds the steer bit, and both read back.
- R11: System config (0x010) bit 0 is an autoidle flag that reads back in bit 0. Writing bit 1 resets all state, including autoidle, on that clock. The idle register (0x050) keeps 2 bits.
- R12: Bank index 3 (slot 0xE0, level words 0x280..0x2FC) ignores writes and reads 0. The protection register (0x04C) reads 0. Writes to read-only registers (raw inputs, winner codes) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | NUM_BANKS*32 | Level interrupt request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_out | output | 1 | Normal interrupt output |
| fiq_out | output | 1 | Fast interrupt output |

## Verification
A register write commits on one rising edge, and read data follows the address combinationally. The bench drives each write across one edge and samples reads at the following falling edge. Input edges reach the raw and pending words one edge after they are driven, and an output rises one edge later, so output checks wait two falling edges after the input change. Clearing the global mask or sending a software-set write raises an output one edge after that write has committed. A re-arm write lowers the output on its own edge. The bench samples right after that edge to see the drop, and one edge later to see the output rise again with the new code.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int LINES_PER_BANK = 32;
  localparam int LINE_W = 5;

  // Bank register select, taken from address bits 4:2 of the bank window
  typedef enum logic [2:0] {
    BR_RAW      = 3'd0,
    BR_MASK     = 3'd1,
    BR_MASK_CLR = 3'd2,
    BR_MASK_SET = 3'd3,
    BR_SW_SET   = 3'd4,
    BR_SW_CLR   = 3'd5,
    BR_PEND_IRQ = 3'd6,
    BR_PEND_FIQ = 3'd7
  } bank_reg_e;

  // Global word addresses (byte address bits 11:2)
  localparam logic [9:0] WA_REV    = 10'h000;
  localparam logic [9:0] WA_SYSCFG = 10'h004;
  localparam logic [9:0] WA_STATUS = 10'h005;
  localparam logic [9:0] WA_IRQWIN = 10'h010;
  localparam logic [9:0] WA_FIQWIN = 10'h011;
  localparam logic [9:0] WA_CTRL   = 10'h012;
  localparam logic [9:0] WA_PROT   = 10'h013;
  localparam logic [9:0] WA_IDLE   = 10'h014;

  // Mask update for the three mask-writing bank registers
  function automatic logic [31:0] mask_apply(input bank_reg_e op,
                                             input logic [31:0] cur,
                                             input logic [31:0] data);
    case (op)
      BR_MASK:     return data;
      BR_MASK_CLR: return cur & ~data;
      BR_MASK_SET: return cur | data;
      default:     return cur;
    endcase
  endfunction

  // Pending update from line edges; any fall rebuilds the whole bank word
  function automatic logic [31:0] line_events(input logic [31:0] pend,
                                              input logic [31:0] raw_q,
                                              input logic [31:0] lines,
                                              input logic [31:0] swi);
    logic [31:0] rise, fall;
    rise = lines & ~raw_q;
    fall = raw_q & ~lines;
    if (|fall) return lines | swi;
    return pend | rise;
  endfunction

  // Lines routed to one output: pending, unmasked, steer matching
  function automatic logic [31:0] route(input logic [31:0] pend,
                                        input logic [31:0] mask,
                                        input logic [31:0] steer,
                                        input logic want_fiq);
    return pend & ~mask & (want_fiq ? steer : ~steer);
  endfunction
endpackage

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int PRI_W = 6
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  soft_clr,
  input  logic [LINES_PER_BANK-1:0]             lines_i,
  input  logic                                  reg_we,
  input  bank_reg_e                             reg_sel,
  input  logic [31:0]                           wdata,
  input  logic                                  lvl_we,
  input  logic [LINE_W-1:0]                     lvl_line,
  output logic [LINES_PER_BANK-1:0]             raw_o,
  output logic [LINES_PER_BANK-1:0]             pend_o,
  output logic [LINES_PER_BANK-1:0]             mask_o,
  output logic [LINES_PER_BANK-1:0]             swi_o,
  output logic [LINES_PER_BANK-1:0]             steer_o,
  output logic [LINES_PER_BANK-1:0][PRI_W-1:0]  pri_o
);
  logic [31:0] raw_q, pend_q, mask_q, swi_q, steer_q;
  logic [31:0][PRI_W-1:0] pri_q;
  logic [31:0] swi_d, mask_d, pend_bus, pend_d;

  always_comb begin
    swi_d    = swi_q;
    pend_bus = pend_q;
    mask_d   = mask_q;
    if (reg_we) begin
      mask_d = mask_apply(reg_sel, mask_q, wdata);
      case (reg_sel)
        BR_SW_SET: begin
          swi_d    = swi_q | wdata;
          pend_bus = pend_q | swi_d;
        end
        BR_SW_CLR: begin
          swi_d    = swi_q & ~wdata;
          pend_bus = swi_d & raw_q;
        end
        default: ;
      endcase
    end
    pend_d = line_events(pend_bus, raw_q, lines_i, swi_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q   <= '0;
      pend_q  <= '0;
      mask_q  <= '1;
      swi_q   <= '0;
      steer_q <= '0;
      pri_q   <= '0;
    end else if (soft_clr) begin
      raw_q   <= '0;
      pend_q  <= '0;
      mask_q  <= '1;
      swi_q   <= '0;
      steer_q <= '0;
      pri_q   <= '0;
    end else begin
      raw_q  <= lines_i;
      pend_q <= pend_d;
      mask_q <= mask_d;
      swi_q  <= swi_d;
      if (lvl_we) begin
        pri_q[lvl_line]   <= wdata[2 +: PRI_W];
        steer_q[lvl_line] <= wdata[0];
      end
    end
  end

  assign raw_o   = raw_q;
  assign pend_o  = pend_q;
  assign mask_o  = mask_q;
  assign swi_o   = swi_q;
  assign steer_o = steer_q;
  assign pri_o   = pri_q;
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int N      = 96,
  parameter int PRI_W  = 6,
  parameter int CODE_W = 7
) (
  input  logic [N-1:0]            active,
  input  logic [N-1:0][PRI_W-1:0] pri,
  output logic                    any,
  output logic [CODE_W-1:0]       code
);
  logic [PRI_W-1:0] best;

  // Upward scan with <= so the last of equal priorities (highest line) wins
  always_comb begin
    best = '1;
    code = '0;
    any  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (active[i] && (pri[i] <= best)) begin
        best = pri[i];
        code = CODE_W'(i);
        any  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intc_out_stage.sv
module intc_out_stage #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              rearm,
  input  logic              gmask,
  input  logic              any,
  input  logic [CODE_W-1:0] win,
  output logic              out_o,
  output logic [CODE_W-1:0] code_o
);
  logic armed_q;
  logic fire;

  assign fire = armed_q & any & ~gmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      out_o   <= 1'b0;
      code_o  <= '0;
    end else if (soft_clr) begin
      armed_q <= 1'b1;
      out_o   <= 1'b0;
      code_o  <= '0;
    end else if (rearm) begin
      armed_q <= 1'b1;
      out_o   <= 1'b0;
    end else if (fire) begin
      armed_q <= 1'b0;
      out_o   <= 1'b1;
      code_o  <= win;
    end
  end
endmodule

// File: rtl/multi_bank_intc.sv
module multi_bank_intc
  import intc_pkg::*;
#(
  parameter int         NUM_BANKS = 3,
  parameter int         PRI_W     = 6,
  parameter logic [7:0] REVISION  = 8'h21
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_BANKS*LINES_PER_BANK-1:0] irq_lines,
  input  logic                                bus_wr,
  input  logic [11:0]                         bus_addr,
  input  logic [31:0]                         bus_wdata,
  output logic [31:0]                         bus_rdata,
  output logic                                irq_out,
  output logic                                fiq_out
);
  localparam int TOTAL  = NUM_BANKS * LINES_PER_BANK;
  localparam int CODE_W = $clog2(TOTAL);

  // ---------------- address decode ----------------
  logic            aligned;
  logic [9:0]      wa;
  logic            in_bank_win, bank_ok;
  logic [1:0]      bsel;
  bank_reg_e       breg;
  logic [11:2]     lvl_off;
  logic            in_lvl, lvl_ok;
  logic [1:0]      lsel;
  logic [LINE_W-1:0] lline;

  assign aligned     = (bus_addr[1:0] == 2'b00);
  assign wa          = bus_addr[11:2];
  assign in_bank_win = aligned && (bus_addr[11:7] == 5'd1);
  assign bsel        = bus_addr[6:5];
  assign breg        = bank_reg_e'(bus_addr[4:2]);
  assign bank_ok     = in_bank_win && (32'(bsel) < NUM_BANKS);
  assign lvl_off     = bus_addr[11:2] - 10'h040;
  assign in_lvl      = aligned && (bus_addr[11:8] != 4'd0) && (lvl_off[11:9] == 3'd0);
  assign lsel        = lvl_off[8:7];
  assign lline       = lvl_off[6:2];
  assign lvl_ok      = in_lvl && (32'(lsel) < NUM_BANKS);

  logic glob_hit, syscfg_we, ctrl_we, idle_we, soft_clr;
  assign glob_hit  = aligned && (bus_addr[11:7] == 5'd0);
  assign syscfg_we = bus_wr && glob_hit && (wa == WA_SYSCFG);
  assign ctrl_we   = bus_wr && glob_hit && (wa == WA_CTRL);
  assign idle_we   = bus_wr && glob_hit && (wa == WA_IDLE);
  assign soft_clr  = syscfg_we && bus_wdata[1];

  // ---------------- global registers ----------------
  logic       autoidle_q, gmask_q;
  logic [1:0] idle_q;
  logic [1:0] rearm_v;

  assign rearm_v = ctrl_we ? bus_wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      autoidle_q <= 1'b0;
      gmask_q    <= 1'b0;
      idle_q     <= 2'b00;
    end else if (soft_clr) begin
      autoidle_q <= 1'b0;
      gmask_q    <= 1'b0;
      idle_q     <= 2'b00;
    end else begin
      if (syscfg_we) autoidle_q <= bus_wdata[0];
      if (ctrl_we)   gmask_q    <= bus_wdata[2];
      if (idle_we)   idle_q     <= bus_wdata[1:0];
    end
  end

  // ---------------- banks ----------------
  logic [NUM_BANKS-1:0][LINES_PER_BANK-1:0]            raw_v, pend_v, mask_v, swi_v, steer_v;
  logic [NUM_BANKS-1:0][LINES_PER_BANK-1:0][PRI_W-1:0] pri_v;
  logic [1:0][TOTAL-1:0]                               act_v;
  logic [TOTAL-1:0][PRI_W-1:0]                         all_pri;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    intc_bank #(.PRI_W(PRI_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_clr),
      .lines_i  (irq_lines[b*LINES_PER_BANK +: LINES_PER_BANK]),
      .reg_we   (bus_wr && bank_ok && (bsel == 2'(b))),
      .reg_sel  (breg),
      .wdata    (bus_wdata),
      .lvl_we   (bus_wr && lvl_ok && (lsel == 2'(b))),
      .lvl_line (lline),
      .raw_o    (raw_v[b]),
      .pend_o   (pend_v[b]),
      .mask_o   (mask_v[b]),
      .swi_o    (swi_v[b]),
      .steer_o  (steer_v[b]),
      .pri_o    (pri_v[b])
    );
    assign act_v[0][b*LINES_PER_BANK +: LINES_PER_BANK] = route(pend_v[b], mask_v[b], steer_v[b], 1'b0);
    assign act_v[1][b*LINES_PER_BANK +: LINES_PER_BANK] = route(pend_v[b], mask_v[b], steer_v[b], 1'b1);
    assign all_pri[b*LINES_PER_BANK +: LINES_PER_BANK]  = pri_v[b];
  end

  // ---------------- arbitration and outputs (0 = IRQ, 1 = FIQ) ----------------
  logic [1:0]             any_v;
  logic [1:0][CODE_W-1:0] win_v, code_v;
  logic [1:0]             out_v;

  for (genvar k = 0; k < 2; k++) begin : g_out
    intc_arbiter #(.N(TOTAL), .PRI_W(PRI_W), .CODE_W(CODE_W)) u_arb (
      .active (act_v[k]),
      .pri    (all_pri),
      .any    (any_v[k]),
      .code   (win_v[k])
    );
    intc_out_stage #(.CODE_W(CODE_W)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_clr),
      .rearm    (rearm_v[k]),
      .gmask    (gmask_q),
      .any      (any_v[k]),
      .win      (win_v[k]),
      .out_o    (out_v[k]),
      .code_o   (code_v[k])
    );
  end

  assign irq_out = out_v[0];
  assign fiq_out = out_v[1];

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    if (in_bank_win) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bank_ok && (bsel == 2'(b))) begin
          case (breg)
            BR_RAW:      bus_rdata = raw_v[b];
            BR_MASK:     bus_rdata = mask_v[b];
            BR_SW_SET:   bus_rdata = swi_v[b];
            BR_PEND_IRQ: bus_rdata = route(pend_v[b], mask_v[b], steer_v[b], 1'b0);
            BR_PEND_FIQ: bus_rdata = route(pend_v[b], mask_v[b], steer_v[b], 1'b1);
            default:     bus_rdata = '0;
          endcase
        end
      end
    end else if (in_lvl) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (lvl_ok && (lsel == 2'(b)))
          bus_rdata = 32'({pri_v[b][lline], 1'b0, steer_v[b][lline]});
      end
    end else if (glob_hit) begin
      case (wa)
        WA_REV:    bus_rdata = 32'(REVISION);
        WA_SYSCFG: bus_rdata = 32'(autoidle_q);
        WA_STATUS: bus_rdata = 32'd1;
        WA_IRQWIN: bus_rdata = 32'(code_v[0]);
        WA_FIQWIN: bus_rdata = 32'(code_v[1]);
        WA_CTRL:   bus_rdata = {29'd0, gmask_q, 2'b00};
        WA_IDLE:   bus_rdata = 32'(idle_q);
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int CODE_W = 7,
  parameter int TOTAL  = 96
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_clr,
  input logic [1:0]        rearm,
  input logic              gmask,
  input logic [1:0]        any,
  input logic [1:0]        out,
  input logic [CODE_W-1:0] irq_code,
  input logic [CODE_W-1:0] fiq_code
);
  AST_REARM_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    rearm[0] |=> !out[0]); // R8
  AST_REARM_DROPS_FIQ: assert property (@(posedge clk) disable iff (!rst_n)
    rearm[1] |=> !out[1]); // R8
  AST_HOLD_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (out[0] && !rearm[0] && !soft_clr) |=> (out[0] && $stable(irq_code))); // R8
  AST_HOLD_FIQ: assert property (@(posedge clk) disable iff (!rst_n)
    (out[1] && !rearm[1] && !soft_clr) |=> (out[1] && $stable(fiq_code))); // R8
  AST_GMASK_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (gmask && !out[0]) |=> !out[0]); // R9
  AST_GMASK_BLOCKS_FIQ: assert property (@(posedge clk) disable iff (!rst_n)
    (gmask && !out[1]) |=> !out[1]); // R9
  AST_RISE_HAS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out[0]) |-> $past(any[0])); // R6
  AST_RISE_HAS_WINNER_FIQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out[1]) |-> $past(any[1])); // R7
  AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(irq_code) < TOTAL) && (32'(fiq_code) < TOTAL)); // R6
  AST_SOFT_RESET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (!out[0] && !out[1])); // R11
endmodule

bind multi_bank_intc intc_checker #(.CODE_W(CODE_W), .TOTAL(TOTAL)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .soft_clr (soft_clr),
  .rearm    (rearm_v),
  .gmask    (gmask_q),
  .any      (any_v),
  .out      (out_v),
  .irq_code (code_v[0]),
  .fiq_code (code_v[1])
);

// File: tb/multi_bank_intc_test.sv
module multi_bank_intc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] lines = '0;
  logic        wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o, fiq_o;
  int          n_checks = 0;
  int          n_err = 0;

  always #10 clk = ~clk; // 50 MHz

  multi_bank_intc uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (lines),
    .bus_wr    (wr),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq_out   (irq_o),
    .fiq_out   (fiq_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(req, $sformatf("read @%h", a), rdata, exp);
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // R1: reset values
  task automatic t_reset();
    check("R1", "irq_out", 32'(irq_o), 0);
    check("R1", "fiq_out", 32'(fiq_o), 0);
    rd_check("R1", 12'h084, 32'hFFFF_FFFF);
    rd_check("R1", 12'h0A4, 32'hFFFF_FFFF);
    rd_check("R1", 12'h000, 32'h21);
    rd_check("R1", 12'h014, 32'h1);
    rd_check("R1", 12'h040, 32'h0);
  endtask

  // R2, R4, R6, R7: rising inputs, views, mask aliases
  task automatic t_rise();
    wr_reg(12'h084, 32'h0);
    wr_reg(12'h114, 32'h1);          // bank0 line5 steer to FIQ
    @(negedge clk);
    lines[3] = 1'b1; lines[5] = 1'b1;
    wait_neg(2);
    rd_check("R2", 12'h080, 32'h28);
    rd_check("R2", 12'h098, 32'h08);
    rd_check("R2", 12'h09C, 32'h20);
    check("R6", "irq_out after rise", 32'(irq_o), 1);
    check("R7", "fiq_out after steered rise", 32'(fiq_o), 1);
    rd_check("R7", 12'h040, 32'd3);
    rd_check("R7", 12'h044, 32'd5);
    wr_reg(12'h08C, 32'h8);
    rd_check("R4", 12'h084, 32'h8);
    rd_check("R4", 12'h098, 32'h0);
    check("R4", "irq_out held after mask-set", 32'(irq_o), 1);
    wr_reg(12'h088, 32'hFFFF_FFFF);
    rd_check("R4", 12'h084, 32'h0);
    rd_check("R4", 12'h088, 32'h0);
    rd_check("R4", 12'h08C, 32'h0);
  endtask

  // R3, R5: falling input and software bits
  task automatic t_fall_sw();
    wr_reg(12'h090, 32'h400);
    rd_check("R5", 12'h090, 32'h400);
    rd_check("R5", 12'h098, 32'h408);
    lines[3] = 1'b0;
    wait_neg(1);
    rd_check("R3", 12'h080, 32'h20);
    rd_check("R3", 12'h098, 32'h400);
    rd_check("R3", 12'h09C, 32'h20);
    wr_reg(12'h094, 32'h400);
    rd_check("R5", 12'h090, 32'h0);
    rd_check("R5", 12'h098, 32'h0);
    rd_check("R5", 12'h09C, 32'h0);
    lines = '0;
    wait_neg(2);
  endtask

  // R6, R8, R9, R10, R11: arbitration across banks, global mask, re-arm
  task automatic t_arb();
    wr_reg(12'h010, 32'h2);
    check("R11", "irq_out after soft reset", 32'(irq_o), 0);
    check("R11", "fiq_out after soft reset", 32'(fiq_o), 0);
    rd_check("R11", 12'h084, 32'hFFFF_FFFF);
    rd_check("R11", 12'h114, 32'h0);
    rd_check("R11", 12'h044, 32'h0);
    rd_check("R11", 12'h010, 32'h0);
    wr_reg(12'h048, 32'h4);
    rd_check("R9", 12'h048, 32'h4);
    wr_reg(12'h188, 32'd28);          // bank1 line2 pri 7
    wr_reg(12'h1A4, 32'd12);          // bank1 line9 pri 3
    wr_reg(12'h1D0, 32'd12);          // bank1 line20 pri 3
    wr_reg(12'h200, 32'd16);          // bank2 line0 pri 4
    wr_reg(12'h0A4, 32'h0);
    wr_reg(12'h0C4, 32'h0);
    @(negedge clk);
    lines[34] = 1'b1; lines[41] = 1'b1; lines[52] = 1'b1; lines[64] = 1'b1;
    wait_neg(3);
    check("R9", "irq_out held low by global mask", 32'(irq_o), 0);
    rd_check("R2", 12'h0B8, 32'h0010_0204);
    wr_reg(12'h048, 32'h0);
    wait_neg(1);
    check("R6", "irq_out after unmask", 32'(irq_o), 1);
    rd_check("R6", 12'h040, 32'd52);
    wr_reg(12'h200, 32'd4);           // bank2 line0 pri 1
    wait_neg(2);
    rd_check("R8", 12'h040, 32'd52);
    check("R8", "irq_out held", 32'(irq_o), 1);
    wr_reg(12'h048, 32'h1);
    check("R8", "irq_out dropped by re-arm", 32'(irq_o), 0);
    wait_neg(1);
    check("R8", "irq_out after re-arm", 32'(irq_o), 1);
    rd_check("R8", 12'h040, 32'd64);
    rd_check("R10", 12'h200, 32'd4);
    rd_check("R10", 12'h1A4, 32'd12);
    check("R7", "fiq_out idle", 32'(fiq_o), 0);
  endtask

  // R11, R12, R5: config, ignored accesses, soft reset, software raise
  task automatic t_misc();
    wr_reg(12'h010, 32'h1);
    rd_check("R11", 12'h010, 32'h1);
    wr_reg(12'h050, 32'h7);
    rd_check("R11", 12'h050, 32'h3);
    wr_reg(12'h04C, 32'h1);
    rd_check("R12", 12'h04C, 32'h0);
    wr_reg(12'h040, 32'h5);
    rd_check("R12", 12'h040, 32'd64);
    wr_reg(12'h0E4, 32'h0);
    rd_check("R12", 12'h0E4, 32'h0);
    rd_check("R12", 12'h084, 32'hFFFF_FFFF);
    wr_reg(12'h0F0, 32'hFFFF_FFFF);
    rd_check("R12", 12'h090, 32'h0);
    rd_check("R12", 12'h0B0, 32'h0);
    rd_check("R12", 12'h0D0, 32'h0);
    wr_reg(12'h080, 32'hFFFF_FFFF);
    rd_check("R12", 12'h080, 32'h0);
    wr_reg(12'h280, 32'hFC);
    rd_check("R12", 12'h100, 32'h0);
    rd_check("R12", 12'h280, 32'h0);
    wr_reg(12'h010, 32'h3);
    check("R11", "irq_out after second soft reset", 32'(irq_o), 0);
    rd_check("R11", 12'h010, 32'h0);
    rd_check("R11", 12'h050, 32'h0);
    rd_check("R11", 12'h040, 32'h0);
    rd_check("R11", 12'h200, 32'h0);
    wait_neg(2);
    check("R11", "irq_out stays low, masked", 32'(irq_o), 0);
    wr_reg(12'h084, 32'h0);
    wr_reg(12'h090, 32'h80);
    wait_neg(1);
    check("R5", "irq_out from software-set", 32'(irq_o), 1);
    rd_check("R5", 12'h040, 32'd7);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(1);
    t_reset();
    t_rise();
    t_fall_sw();
    t_arb();
    t_misc();
    wait_neg(2);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule